// File: doc/BRIEF.md
# Branch Delay-Slot Commit Controller

This block sits beside the decode stage of a pipeline with delayed branches and a single delay slot. Branch conditions are resolved in decode. So when a branch resolves, the instruction behind it in fetch is always the one in its delay slot. No other instruction is ever discarded. The block records what must happen to that slot instruction and chooses the next fetch address.

When the branch leaves decode, the controller works out the slot's fate from two things: the branch's kind and its resolved direction. The fate is one of two outcomes:

- the slot instruction commits normally, or
- its valid bit is cleared so that it becomes a nop with no register write, memory access or exception.

In the same cycle, the controller steers fetch past the slot. Fetch goes to the branch target when the branch is taken, and otherwise to the sequential address after the slot.

The controller is a three-state machine:

- `ST_IDLE`: no slot is outstanding.
- `ST_SLOT_KEEP`: the slot instruction is owed and will commit.
- `ST_SLOT_DROP`: the slot instruction is owed and will be nullified.

The state machine has these transitions:

- *accept-keep* moves from `ST_IDLE` to `ST_SLOT_KEEP`. It fires when a branch advances out of decode and its slot survives.
- *accept-drop* moves from `ST_IDLE` to `ST_SLOT_DROP`. It fires when the slot is to be cancelled.
- *slot-wait* keeps either slot state while decode is stalled or holds a bubble.
- *slot-retire* returns to `ST_IDLE` once a valid instruction, the slot, advances out of decode.

A branch found in a slot state is illegal. It raises an error strobe and is never accepted as a branch.

Top module: `dsn_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first cycle after it, `slot_pending`, `slot_commit`, `slot_nullify` and `slot_err` are all 0.
- R2: For kind code 0 (plain delayed branch), the slot instruction commits whether the branch is taken or not.
- R3: For kind code 1 (likely branch), the slot commits when the branch is taken and is nullified when it is not taken.
- R4: For kind code 2 (canceling branch), the slot commits when `dec_taken` equals the prediction bit `dec_pred`, and is nullified when they differ.
- R5: Kind code 3 is reserved and behaves exactly as kind code 0.
- R6: `npc_sel` encodes 0 = sequential, 1 = target, 2 = hold. A branch advancing out of decode from `ST_IDLE` gives 1 when taken and 0 when not taken. Any cycle with `adv` low gives 2. A branch held stalled in decode creates no slot.
- R7: The slot state is entered on the cycle after the branch advances. It persists through stall cycles (`adv` low) and bubble cycles (`dec_valid` low). It ends on the cycle after a valid instruction advances out of decode.
- R8: A branch in decode during a slot state raises `slot_err`. It causes no redirect (`npc_sel` is 0 when it advances) and does not open a new slot.
- R9: A non-branch or invalid decode entry in `ST_IDLE` gives `npc_sel` 0 when `adv` is high, and opens no slot.
- R10: `slot_commit` and `slot_nullify` are asserted only while the slot instruction is valid in decode, and are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Decode stage advances this cycle |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_is_br | input | 1 | Instruction in decode is a conditional branch |
| dec_kind | input | 2 | Branch kind: 0 plain, 1 likely, 2 canceling, 3 reserved |
| dec_pred | input | 1 | Predicted direction carried by a canceling branch (1 = taken) |
| dec_taken | input | 1 | Resolved branch outcome (1 = taken) |
| npc_sel | output | 2 | Next-fetch select: 0 sequential, 1 target, 2 hold |
| slot_pending | output | 1 | A delay-slot decision is outstanding |
| slot_commit | output | 1 | Slot instruction in decode commits |
| slot_nullify | output | 1 | Slot instruction in decode has its valid bit cleared |
| slot_err | output | 1 | Branch found in a delay slot |

## Verification
Several relations are checked on every cycle:

- Commit and nullify are never asserted together, and both are quiet outside a slot.
- A plain branch never kills its slot.
- An untaken likely branch always kills its slot.
- A matching canceling prediction never kills its slot.
- A target redirect always opens a slot.
- The slot state persists until a valid instruction retires it.

The exact interplay needs the scenario sweep, which crosses every kind, prediction and outcome with stalls before and after the branch, bubbles, and a nested branch in the slot. That interplay covers when `npc_sel` changes, whether the decision survives stalls, and which cycle the error strobe lands on.

// File: rtl/dsn_pkg.sv
package dsn_pkg;

    typedef enum logic [1:0] {
        BK_PLAIN  = 2'd0,
        BK_LIKELY = 2'd1,
        BK_CANCEL = 2'd2,
        BK_RSVD   = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        NS_SEQ    = 2'd0,
        NS_TARGET = 2'd1,
        NS_HOLD   = 2'd2
    } npc_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SLOT_KEEP = 2'd1,
        ST_SLOT_DROP = 2'd2
    } slot_state_e;

endpackage

// File: rtl/dsn_rule.sv
module dsn_rule
    import dsn_pkg::*;
(
    input  br_kind_e kind,
    input  logic     pred,
    input  logic     taken,
    output logic     kill
);

    always_comb begin
        unique case (kind)
            BK_LIKELY: kill = !taken;
            BK_CANCEL: kill = taken ^ pred;
            default:   kill = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsn_fsm.sv
module dsn_fsm
    import dsn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_go,
    input  logic        kill,
    input  logic        retire,
    input  logic        dec_valid,
    input  logic        dec_is_br,
    output slot_state_e state,
    output logic        pending,
    output logic        commit,
    output logic        nullify,
    output logic        err
);

    slot_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (br_go) state_nx = kill ? ST_SLOT_DROP : ST_SLOT_KEEP;
            end
            ST_SLOT_KEEP, ST_SLOT_DROP: begin
                if (retire) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending = 1'b0;
        commit  = 1'b0;
        nullify = 1'b0;
        err     = 1'b0;
        unique case (state)
            ST_SLOT_KEEP: begin
                pending = 1'b1;
                commit  = dec_valid;
                err     = dec_valid && dec_is_br;
            end
            ST_SLOT_DROP: begin
                pending = 1'b1;
                nullify = dec_valid;
                err     = dec_valid && dec_is_br;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dsn_steer.sv
module dsn_steer
    import dsn_pkg::*;
(
    input  logic     adv,
    input  logic     br_go,
    input  logic     taken,
    output npc_sel_e sel
);

    always_comb begin
        if (!adv)               sel = NS_HOLD;
        else if (br_go && taken) sel = NS_TARGET;
        else                     sel = NS_SEQ;
    end

endmodule

// File: rtl/dsn_ctrl.sv
module dsn_ctrl
    import dsn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       dec_valid,
    input  logic       dec_is_br,
    input  logic [1:0] dec_kind,
    input  logic       dec_pred,
    input  logic       dec_taken,
    output logic [1:0] npc_sel,
    output logic       slot_pending,
    output logic       slot_commit,
    output logic       slot_nullify,
    output logic       slot_err
);

    slot_state_e st;
    npc_sel_e    sel;
    logic        kill;
    logic        br_go;
    logic        retire;

    // a branch is accepted only from idle, when it leaves decode
    assign br_go  = adv && dec_valid && dec_is_br && !slot_pending;
    assign retire = adv && dec_valid;

    dsn_rule u_rule (
        .kind  (br_kind_e'(dec_kind)),
        .pred  (dec_pred),
        .taken (dec_taken),
        .kill  (kill)
    );

    dsn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_go     (br_go),
        .kill      (kill),
        .retire    (retire),
        .dec_valid (dec_valid),
        .dec_is_br (dec_is_br),
        .state     (st),
        .pending   (slot_pending),
        .commit    (slot_commit),
        .nullify   (slot_nullify),
        .err       (slot_err)
    );

    dsn_steer u_steer (
        .adv   (adv),
        .br_go (br_go),
        .taken (dec_taken),
        .sel   (sel)
    );

    assign npc_sel = sel;

endmodule

// File: rtl/dsn_ctrl_chk.sv
module dsn_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       adv,
    input logic       dec_valid,
    input logic       dec_is_br,
    input logic [1:0] dec_kind,
    input logic       dec_pred,
    input logic       dec_taken,
    input logic [1:0] npc_sel,
    input logic       slot_pending,
    input logic       slot_commit,
    input logic       slot_nullify,
    input logic       slot_err
);

    logic accept;
    assign accept = adv && dec_valid && dec_is_br && !slot_pending;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_commit && slot_nullify)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pending |-> (!slot_commit && !slot_nullify && !slot_err)); // R10
    AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_kind == 2'd0) |=> (slot_pending && !slot_nullify)); // R2
    AST_LIKELY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_kind == 2'd1 && !dec_taken) |=> (slot_pending && (slot_nullify == dec_valid))); // R3
    AST_CANCEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_kind == 2'd2 && dec_taken == dec_pred) |=> !slot_nullify); // R4
    AST_TARGET_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_sel == 2'd1) |=> slot_pending); // R6
    AST_ERR_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> (npc_sel != 2'd1)); // R8
    AST_SLOT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pending && adv && dec_valid) |=> !slot_pending); // R7
    AST_SLOT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pending && !(adv && dec_valid)) |=> slot_pending); // R7

endmodule

bind dsn_ctrl dsn_ctrl_chk u_chk (.*);

// File: tb/test_dsn_ctrl.sv
module test_dsn_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv = 1'b0;
    logic       dec_valid = 1'b0;
    logic       dec_is_br = 1'b0;
    logic [1:0] dec_kind = 2'd0;
    logic       dec_pred = 1'b0;
    logic       dec_taken = 1'b0;
    logic [1:0] npc_sel;
    logic       slot_pending, slot_commit, slot_nullify, slot_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    dsn_ctrl i_dsn_ctrl (
        .clk(clk), .rst_n(rst_n), .adv(adv), .dec_valid(dec_valid),
        .dec_is_br(dec_is_br), .dec_kind(dec_kind), .dec_pred(dec_pred),
        .dec_taken(dec_taken), .npc_sel(npc_sel), .slot_pending(slot_pending),
        .slot_commit(slot_commit), .slot_nullify(slot_nullify), .slot_err(slot_err)
    );

    task automatic drive(input logic a, input logic v, input logic b,
                         input logic [1:0] k, input logic p, input logic t);
        @(posedge clk);
        #1;
        adv = a; dec_valid = v; dec_is_br = b; dec_kind = k; dec_pred = p; dec_taken = t;
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] e_sel, input logic e_pend,
                       input logic e_com, input logic e_nul, input logic e_err);
        n_chk++;
        if (npc_sel !== e_sel || slot_pending !== e_pend || slot_commit !== e_com ||
            slot_nullify !== e_nul || slot_err !== e_err) begin
            n_bad++;
            $display("FAIL %s: got sel=%0d pend=%0b com=%0b nul=%0b err=%0b exp sel=%0d pend=%0b com=%0b nul=%0b err=%0b",
                     req, npc_sel, slot_pending, slot_commit, slot_nullify, slot_err,
                     e_sel, e_pend, e_com, e_nul, e_err);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (3) begin
            drive(1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
            n_chk++;
            if (slot_pending || slot_commit || slot_nullify || slot_err) begin
                n_bad++;
                $display("FAIL R1: got pend=%0b com=%0b nul=%0b err=%0b exp all 0",
                         slot_pending, slot_commit, slot_nullify, slot_err);
            end
        end
        drive(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R1", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        for (int k = 0; k < 4; k++)
        for (int p = 0; p < 2; p++)
        for (int t = 0; t < 2; t++)
        for (int ps = 0; ps < 2; ps++)
        for (int s = 0; s < 3; s++)
        for (int bb = 0; bb < 2; bb++)
        for (int nest = 0; nest < 2; nest++) begin
            logic kl;
            string rq;
            kl = (k == 1) ? !t[0] : (k == 2) ? (t[0] != p[0]) : 1'b0;
            rq = (k == 1) ? "R3" : (k == 2) ? "R4" : (k == 3) ? "R5" : "R2";
            // R6: branch stalled in decode, no slot yet
            for (int i = 0; i < ps; i++) begin
                drive(1'b0, 1'b1, 1'b1, k[1:0], p[0], t[0]);
                chk("R6 stalled branch", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
            end
            // R6: branch advances
            drive(1'b1, 1'b1, 1'b1, k[1:0], p[0], t[0]);
            chk("R6 redirect", t[0] ? 2'd1 : 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
            // R7: stalled slot instruction keeps the decision
            for (int i = 0; i < s; i++) begin
                drive(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
                chk(rq, 2'd2, 1'b1, !kl, kl, 1'b0);
            end
            // R7: bubble in decode
            for (int i = 0; i < bb; i++) begin
                drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
                chk("R7 bubble", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
            end
            // slot instruction advances; R8 when it is a branch
            drive(1'b1, 1'b1, nest[0], k[1:0], 1'b0, 1'b1);
            chk(nest ? "R8" : rq, 2'd0, 1'b1, !kl, kl, nest[0]);
            // R9: after the slot, plain instruction, idle again
            drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
            chk("R9", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
            // R9: invalid entry marked branch opens nothing
            drive(1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1);
            chk("R9 invalid", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
            drive(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
            chk("R10 idle", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule